// File: doc/BRIEF.md
# Per-Source Interrupt Pending Tracker with Level Tracking

This block keeps one pending bit and one enable bit for each of `NSRC` interrupt sources. It drives a single request line toward one hart. Each source has a trigger mode: inactive, rising edge, falling edge, active-high level or active-low level. Raw inputs are first passed through a multi-flop synchronizer. The synchronized value is then turned into a rectified level (level modes) or an edge pulse (edge modes).

In the two level modes the pending bit is a live copy of the rectified input. It is set when the rectified input is high and cleared when it is low. A source that drops its request therefore withdraws it with no software step, and no stale interrupt is left behind. In edge modes the pending bit is sticky until it is claimed or the source is reconfigured.

Software takes interrupts with a one-cycle claim strobe. The claim returns the lowest-numbered source that is both pending and enabled, and it clears that source's pending bit. Configuration writes address one source at a time, by index.

Top module: `lvl_pend_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every pending bit is 0, `irq` is 0, `claim_id` is 0, and every source is in inactive mode with its enable cleared.
- R2: In active-high level mode (mode code 3), the pending bit copies the raw input. A change on `src_in` becomes visible on the pending bit, and so on `irq`, on the third rising clock edge after the change. This holds for both the set and the clear direction, and the clear needs no claim.
- R3: In active-low level mode (mode code 4), the pending bit copies the inverse of the raw input, with the same three-edge latency as R2.
- R4: In rising-edge mode (mode code 1), a 0-to-1 transition of the synchronized input sets the pending bit. The bit then stays set whatever the input does, until a claim or a configuration write.
- R5: In falling-edge mode (mode code 2), a 1-to-0 transition sets the pending bit. The bit is otherwise sticky, as in R4.
- R6: In inactive mode (code 0) and for the unused codes 5 to 7, the pending bit is held at 0 and the source's input has no effect on `irq` or on claims.
- R7: `irq` is 1 exactly when at least one source is both pending and enabled. A pending source whose enable bit is 0 neither raises `irq` nor wins a claim.
- R8: When `claim_req` is high at a clock edge, `claim_id` from the next cycle holds the winning source's index plus 1. The winner is the lowest-numbered source that is pending and enabled. The value is 0 when no source qualifies. The claim clears the winner's pending bit at that same edge, and `claim_id` holds its value until the next claim.
- R9: When a level-mode source is claimed while its rectified input is still high, its pending bit is 0 for one cycle. It is set again at the following edge.
- R10: A configuration write (`cfg_we` high at an edge) sets the mode code and enable bit of source `cfg_sel` and clears that source's pending bit at the same edge. This is the software clear for edge modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt inputs, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | $clog2(NSRC) | Index of the source being configured |
| cfg_mode | input | 3 | Trigger mode code: 0 off, 1 rise, 2 fall, 3 high, 4 low |
| cfg_en | input | 1 | Enable bit written with the mode |
| claim_req | input | 1 | Claim strobe |
| claim_id | output | $clog2(NSRC+1) | Last claimed ID: source index plus 1, 0 for none |
| irq | output | 1 | Interrupt request to the hart |

## Verification
An input change is due at the pending bit, and so at `irq`, on the third edge after it. The synchronizer takes two edges and the pending register takes one. The bench samples one time unit after edges two and three, to prove the result is neither early nor late. A claim result is due one edge after the strobe. A level source that is still asserted returns after a one-cycle gap, so the bench looks at the cycle right after the claim and at the cycle after that. Configuration writes clear the pending bit on their own edge, and a level source reloads it one edge later. All waits are counted edges from one common sampling instant, never free delays.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

   typedef enum logic [2:0] {
      SM_OFF  = 3'd0,
      SM_RISE = 3'd1,
      SM_FALL = 3'd2,
      SM_HIGH = 3'd3,
      SM_LOW  = 3'd4
   } src_mode_e;

   // Codes 5..7 fold onto the inactive mode.
   function automatic src_mode_e decode_mode(input logic [2:0] code);
      src_mode_e m;
      case (code)
         3'd1:    m = SM_RISE;
         3'd2:    m = SM_FALL;
         3'd3:    m = SM_HIGH;
         3'd4:    m = SM_LOW;
         default: m = SM_OFF;
      endcase
      return m;
   endfunction

   function automatic logic mode_is_level(input src_mode_e m);
      return (m == SM_HIGH) || (m == SM_LOW);
   endfunction

   function automatic logic mode_is_edge(input src_mode_e m);
      return (m == SM_RISE) || (m == SM_FALL);
   endfunction

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lpc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("lpc_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/lpc_src_cell.sv
module lpc_src_cell
   import lpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       cfg_hit,
   input  logic [2:0] cfg_mode,
   input  logic       cfg_en,
   input  logic       claim_hit,
   output logic       pend,
   output logic       en,
   output logic       is_lvl,
   output logic       is_edg,
   output logic       is_off,
   output logic       rect
);

   src_mode_e mode_q;
   logic      en_q;
   logic      prev_q;
   logic      pend_q;
   logic      rise_ev;
   logic      fall_ev;
   logic      edge_ev;

   // Rectified level; only meaningful in level modes.
   always_comb begin
      case (mode_q)
         SM_HIGH: rect = sync_in;
         SM_LOW:  rect = ~sync_in;
         default: rect = 1'b0;
      endcase
   end

   assign rise_ev = sync_in & ~prev_q;
   assign fall_ev = ~sync_in & prev_q;
   assign edge_ev = (mode_q == SM_RISE) ? rise_ev :
                    (mode_q == SM_FALL) ? fall_ev : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SM_OFF;
         en_q   <= 1'b0;
      end else if (cfg_hit) begin
         mode_q <= decode_mode(cfg_mode);
         en_q   <= cfg_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (cfg_hit) begin
         pend_q <= 1'b0;
      end else begin
         case (mode_q)
            SM_HIGH, SM_LOW: begin
               if (claim_hit)            pend_q <= 1'b0;
               else if (rect != pend_q)  pend_q <= rect;
            end
            SM_RISE, SM_FALL: begin
               pend_q <= (pend_q & ~claim_hit) | edge_ev;
            end
            default: pend_q <= 1'b0;
         endcase
      end
   end

   assign pend   = pend_q;
   assign en     = en_q;
   assign is_lvl = mode_is_level(mode_q);
   assign is_edg = mode_is_edge(mode_q);
   assign is_off = (mode_q == SM_OFF);

endmodule

// File: rtl/lpc_prio.sv
module lpc_prio #(
   parameter int N   = 8,
   parameter int IDW = $clog2(N + 1)
) (
   input  logic [N-1:0]   req,
   output logic           any,
   output logic [IDW-1:0] win_id
);

   if (IDW < $clog2(N + 1)) begin : g_bad_idw
      $error("lpc_prio: IDW too narrow for N sources");
   end

   // Scan from the top so the lowest index is written last and wins.
   always_comb begin
      win_id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) win_id = IDW'(i + 1);
      end
   end

   assign any = |req;

endmodule

// File: rtl/lvl_pend_ctrl.sv
module lvl_pend_ctrl
   import lpc_pkg::*;
#(
   parameter  int NSRC        = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int SELW        = $clog2(NSRC),
   localparam int IDW         = $clog2(NSRC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic            cfg_we,
   input  logic [SELW-1:0] cfg_sel,
   input  logic [2:0]      cfg_mode,
   input  logic            cfg_en,
   input  logic            claim_req,
   output logic [IDW-1:0]  claim_id,
   output logic            irq
);

   if (NSRC < 2 || NSRC > 1023) begin : g_bad_nsrc
      $error("lvl_pend_ctrl: NSRC must lie in 2..1023");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lvl_pend_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NSRC-1:0] src_sync;
   logic [NSRC-1:0] pend_vec;
   logic [NSRC-1:0] en_vec;
   logic [NSRC-1:0] lvl_vec;
   logic [NSRC-1:0] edg_vec;
   logic [NSRC-1:0] off_vec;
   logic [NSRC-1:0] rect_vec;
   logic [NSRC-1:0] claim_hit;
   logic [NSRC-1:0] cfg_hit;
   logic [NSRC-1:0] live_vec;
   logic [IDW-1:0]  win_id;
   logic            any_live;
   logic [IDW-1:0]  claim_id_q;

   lpc_sync #(
      .W      (NSRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (src_in),
      .dout  (src_sync)
   );

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign cfg_hit[g]   = cfg_we && (cfg_sel == SELW'(g));
      assign claim_hit[g] = claim_req && (win_id == IDW'(g + 1));

      lpc_src_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_in   (src_sync[g]),
         .cfg_hit   (cfg_hit[g]),
         .cfg_mode  (cfg_mode),
         .cfg_en    (cfg_en),
         .claim_hit (claim_hit[g]),
         .pend      (pend_vec[g]),
         .en        (en_vec[g]),
         .is_lvl    (lvl_vec[g]),
         .is_edg    (edg_vec[g]),
         .is_off    (off_vec[g]),
         .rect      (rect_vec[g])
      );
   end

   assign live_vec = pend_vec & en_vec;

   lpc_prio #(
      .N   (NSRC),
      .IDW (IDW)
   ) u_prio (
      .req    (live_vec),
      .any    (any_live),
      .win_id (win_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         claim_id_q <= '0;
      else if (claim_req) claim_id_q <= win_id;
   end

   assign claim_id = claim_id_q;
   assign irq      = any_live;

endmodule

module lvl_pend_ctrl_chk #(
   parameter int NSRC = 8,
   parameter int IDW  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            claim_req,
   input logic [IDW-1:0]  claim_id,
   input logic            irq,
   input logic [NSRC-1:0] pend_vec,
   input logic [NSRC-1:0] lvl_vec,
   input logic [NSRC-1:0] edg_vec,
   input logic [NSRC-1:0] off_vec,
   input logic [NSRC-1:0] rect_vec,
   input logic [NSRC-1:0] claim_hit
);

   logic [NSRC-1:0] pend_at_id;
   assign pend_at_id = pend_vec >> (claim_id - IDW'(1));

   // R1: reset forces a quiet output.
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (claim_id == '0) && !irq);

   // R6: an inactive source never holds a pending bit.
   a_r6_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (off_vec & pend_vec) == '0);

   // R8: a claim with a live request returns a nonzero ID whose bit was cleared.
   a_r8_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
      claim_req && irq |=> (claim_id != '0) && !pend_at_id[0]);

   // R8: a claim with nothing live returns 0.
   a_r8_claim_none: assert property (@(posedge clk) disable iff (!rst_n)
      claim_req && !irq |=> claim_id == '0);

   // R8: at most one source is taken per claim.
   a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim_hit));

   for (genvar g = 0; g < NSRC; g++) begin : g_chk
      // R2 / R3: a level source's pending bit follows the rectified input.
      a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_vec[g] && !cfg_we && !claim_hit[g] |=> pend_vec[g] == $past(rect_vec[g]));

      // R4 / R5: an edge source keeps its pending bit until claimed or rewritten.
      a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         edg_vec[g] && pend_vec[g] && !claim_hit[g] && !cfg_we |=> pend_vec[g]);
   end

endmodule

bind lvl_pend_ctrl lvl_pend_ctrl_chk #(
   .NSRC (NSRC),
   .IDW  (IDW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .claim_req (claim_req),
   .claim_id  (claim_id),
   .irq       (irq),
   .pend_vec  (pend_vec),
   .lvl_vec   (lvl_vec),
   .edg_vec   (edg_vec),
   .off_vec   (off_vec),
   .rect_vec  (rect_vec),
   .claim_hit (claim_hit)
);

// File: tb/sim_lvl_pend_ctrl.sv
module sim_lvl_pend_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 8;
   localparam int SELW = 3;
   localparam int IDW  = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NSRC-1:0] src_in;
   logic            cfg_we;
   logic [SELW-1:0] cfg_sel;
   logic [2:0]      cfg_mode;
   logic            cfg_en;
   logic            claim_req;
   logic [IDW-1:0]  claim_id;
   logic            irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvl_pend_ctrl #(.NSRC(NSRC), .SYNC_STAGES(2)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_mode  (cfg_mode),
      .cfg_en    (cfg_en),
      .claim_req (claim_req),
      .claim_id  (claim_id),
      .irq       (irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Every action happens one time unit after a rising edge.
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cfg(input int idx, input int mode, input bit en);
      cfg_we = 1'b1; cfg_sel = SELW'(idx); cfg_mode = 3'(mode); cfg_en = en;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_all(input int mode, input bit en);
      for (int i = 0; i < NSRC; i++) cfg(i, mode, en);
   endtask

   task automatic do_claim(output int id);
      claim_req = 1'b1;
      tick(1);
      claim_req = 1'b0;
      id = int'(claim_id);
   endtask

   function automatic int lowest_id(input logic [NSRC-1:0] m);
      for (int i = 0; i < NSRC; i++) if (m[i]) return i + 1;
      return 0;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int id;
      rst_n = 1'b0; src_in = '0; cfg_we = 1'b0; cfg_sel = '0;
      cfg_mode = '0; cfg_en = 1'b0; claim_req = 1'b0;
      tick(3);
      chk(irq == 1'b0 && claim_id == 0, "R1 reset", int'(irq), 0);
      rst_n = 1'b1;
      tick(2);
      chk(irq == 1'b0, "R1 after release irq", int'(irq), 0);
      chk(claim_id == 0, "R1 after release claim_id", int'(claim_id), 0);

      // R6: inactive by default, unused codes too.
      src_in = '1; tick(5);
      chk(irq == 1'b0, "R6 off ignores high input", int'(irq), 0);
      do_claim(id);
      chk(id == 0, "R6 off claim gives none", id, 0);
      cfg(0, 6, 1'b1); cfg(1, 5, 1'b1); cfg(2, 7, 1'b1);
      src_in = '0; tick(5); src_in = '1; tick(5);
      chk(irq == 1'b0, "R6 unused codes ignore input", int'(irq), 0);
      cfg_all(0, 1'b0);
      src_in = '0; tick(5);

      // R2: active-high latency, set and clear without claim.
      cfg(3, 3, 1'b1); tick(1);
      src_in[3] = 1'b1; tick(2);
      chk(irq == 1'b0, "R2 not before third edge", int'(irq), 0);
      tick(1);
      chk(irq == 1'b1, "R2 set on third edge", int'(irq), 1);
      src_in[3] = 1'b0; tick(2);
      chk(irq == 1'b1, "R2 clear not early", int'(irq), 1);
      tick(1);
      chk(irq == 1'b0, "R2 cleared by input alone", int'(irq), 0);
      cfg(3, 0, 1'b0);

      // R3: active-low.
      src_in[5] = 1'b1; cfg(5, 4, 1'b1); tick(4);
      chk(irq == 1'b0, "R3 high input not pending", int'(irq), 0);
      src_in[5] = 1'b0; tick(2);
      chk(irq == 1'b0, "R3 not before third edge", int'(irq), 0);
      tick(1);
      chk(irq == 1'b1, "R3 low input pending", int'(irq), 1);
      src_in[5] = 1'b1; tick(3);
      chk(irq == 1'b0, "R3 released input clears", int'(irq), 0);
      cfg(5, 0, 1'b0);

      // R4: rising edge, sticky until claim.
      cfg(2, 1, 1'b1); tick(2);
      src_in[2] = 1'b1; tick(3);
      chk(irq == 1'b1, "R4 rise sets pending", int'(irq), 1);
      src_in[2] = 1'b0; tick(6);
      chk(irq == 1'b1, "R4 pending sticky after fall", int'(irq), 1);
      do_claim(id);
      chk(id == 3, "R4 claim id", id, 3);
      chk(irq == 1'b0, "R4 claim clears", int'(irq), 0);
      tick(4);
      chk(irq == 1'b0, "R4 stays clear", int'(irq), 0);

      // R10: configuration write clears an edge-pending bit.
      src_in[2] = 1'b1; tick(3);
      chk(irq == 1'b1, "R10 precondition rise", int'(irq), 1);
      cfg(2, 1, 1'b1);
      chk(irq == 1'b0, "R10 cfg write clears pending", int'(irq), 0);
      tick(3);
      chk(irq == 1'b0, "R10 no reassert while input high", int'(irq), 0);
      cfg(2, 0, 1'b0);
      src_in[2] = 1'b0;

      // R5: falling edge.
      src_in[7] = 1'b1; tick(4);
      cfg(7, 2, 1'b1); tick(2);
      chk(irq == 1'b0, "R5 steady high not pending", int'(irq), 0);
      src_in[7] = 1'b0; tick(2);
      chk(irq == 1'b0, "R5 not before third edge", int'(irq), 0);
      tick(1);
      chk(irq == 1'b1, "R5 fall sets pending", int'(irq), 1);
      src_in[7] = 1'b1; tick(5);
      chk(irq == 1'b1, "R5 sticky after rise", int'(irq), 1);
      do_claim(id);
      chk(id == 8, "R5 claim id", id, 8);
      chk(irq == 1'b0, "R5 claim clears", int'(irq), 0);
      cfg(7, 0, 1'b0);
      src_in = '0; tick(4);

      // R8 / R9 sweep: every input pattern with all sources active-high.
      cfg_all(3, 1'b1);
      for (int m = 0; m < 256; m++) begin
         logic [NSRC-1:0] mask;
         mask = NSRC'(m);
         src_in = mask;
         tick(3);
         chk(irq == (mask != 0), "R7 irq tracks pending", int'(irq), int'(mask != 0));
         do_claim(id);
         chk(id == lowest_id(mask), "R8 lowest claim id", id, lowest_id(mask));
         if ($countones(mask) == 1) begin
            chk(irq == 1'b0, "R9 gap after claim", int'(irq), 0);
            tick(1);
            chk(irq == 1'b1, "R9 level pending returns", int'(irq), 1);
         end else begin
            tick(1);
         end
      end

      // R7 sweep: every enable pattern with all inputs asserted.
      src_in = '1; tick(3);
      for (int m = 0; m < 256; m++) begin
         logic [NSRC-1:0] emask;
         emask = NSRC'(m);
         for (int i = 0; i < NSRC; i++) cfg(i, 3, emask[i]);
         tick(2);
         chk(irq == (emask != 0), "R7 enable gating", int'(irq), int'(emask != 0));
         do_claim(id);
         chk(id == lowest_id(emask), "R7 claim skips disabled", id, lowest_id(emask));
         tick(1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule